// File: doc/BRIEF.md
# Daisy-chain converter readback controller

This block is the host side of a three-wire link to a chain of N serial 16-bit analog-to-digital converters. The converters are wired output-to-input, and the chain uses a busy-indicator scheme. When the block receives a start request, it raises the convert line while the serial clock is held high. This puts every converter in the chain into chain mode with the busy indicator enabled. The block then holds convert high and leaves the clock idle until the data line coming back from the chain goes high. That transition means every converter has finished its conversion.

It then produces 16×N+1 serial clock pulses. The half-period of each pulse is a whole number of system clock cycles. The block samples the returning line at each falling edge, taking the value present just before that edge. The first sample is the busy-high level and is thrown away. The remaining 16×N bits arrive as N words, each MSB first, starting with the converter nearest the host. When the last pulse is complete, convert drops. At the same moment the assembled words appear on a held output bus, together with a one-cycle done pulse.

If the busy indication does not arrive within a parameterised number of cycles, the transaction is abandoned and a one-cycle timeout pulse is raised. The number of converters, the clock divider and the wait limit are all parameters.

Top module: `chain_adc_reader`

## Requirements
- R1: After reset, `cnv_o` is 0, `sck_o` is 1, `done_o` and `timeout_o` are 0, and `data_o` is all zeros. `sck_o` is 1 whenever `cnv_o` is 0.
- R2: A start request seen on a clock edge while idle raises `cnv_o` on that edge, and `sck_o` is 1 at the moment `cnv_o` rises.
- R3: While `cnv_o` is high and `sdi_i` has not yet been seen high, `sck_o` stays 1 (no clock pulses).
- R4: A readback produces exactly 16×NDEV+1 falling edges on `sck_o`. Each SCK level lasts HALF_DIV system cycles. The first fall comes HALF_DIV cycles after the edge that sampled `sdi_i` high.
- R5: The word from converter k, counted from the host starting at k=0, is placed in `data_o[16*(NDEV-1-k) +: 16]` with its MSB first in time at the top bit. The first sample, the busy-high level, is discarded.
- R6: `sdi_i` is sampled on the system edge that drives `sck_o` low. That sample is the value present before the falling edge, so a change made just after the fall is not captured at that fall.
- R7: On the edge that returns `sck_o` high after the last fall, `cnv_o` drops, `done_o` pulses for exactly one cycle, and `data_o` is updated. `data_o` then holds until the next done. `cnv_o` falls only together with `done_o` or `timeout_o`.
- R8: If `sdi_i` stays low for WAIT_LIMIT cycles after the start edge, `timeout_o` pulses exactly WAIT_LIMIT cycles after that edge. At the same time `cnv_o` drops, with no SCK pulse, no done pulse and no change to `data_o`.
- R9: A start request while a transaction is in progress is ignored: no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, acted on only when idle |
| sdi_i | input | 1 | Serial data returning from the nearest converter |
| cnv_o | output | 1 | Convert line to every converter |
| sck_o | output | 1 | Serial clock to every converter, idle high |
| data_o | output | 16×NDEV | Assembled words, nearest converter in the top slice |
| done_o | output | 1 | One-cycle pulse when `data_o` is updated |
| timeout_o | output | 1 | One-cycle pulse when the busy indication never arrived |

## Verification
Each result has a fixed cycle:
- `cnv_o` rises on the start edge, so the bench reads it at the next falling system edge.
- The first SCK fall comes HALF_DIV cycles after the edge that sees `sdi_i` high. Done comes 2×(16×NDEV+1)×HALF_DIV cycles after that edge. Timeout comes exactly WAIT_LIMIT edges after the start edge.

The bench drives all stimulus and samples all outputs on falling system edges, and it counts edges rather than waiting open-ended. Its converter model changes the returning line 1 ns after every SCK fall. A capture taken one edge late would therefore misplace every bit, and the word comparison against the arithmetically generated patterns would show it.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } rd_state_e;
endpackage

// File: rtl/rd_cycle_timer.sv
// Counts enabled cycles; tick on the LIMIT-th consecutive enabled cycle.
module rd_cycle_timer #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rd_capture_shreg.sv
// Serial-in shift register; new bits enter at bit 0 and move upward.
module rd_capture_shreg #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_i,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i == 0) begin : g_head
            assign q_d[i] = shift_en ? bit_i : q_q[i];
        end else begin : g_body
            assign q_d[i] = shift_en ? q_q[i-1] : q_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader
    import chain_rd_pkg::*;
#(
    parameter int NDEV       = 3,
    parameter int WORD_W     = 16,
    parameter int HALF_DIV   = 2,
    parameter int WAIT_LIMIT = 4096
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     sdi_i,
    output logic                     cnv_o,
    output logic                     sck_o,
    output logic [NDEV*WORD_W-1:0]   data_o,
    output logic                     done_o,
    output logic                     timeout_o
);
    localparam int BUS_W       = NDEV * WORD_W;
    localparam int TOTAL_FALLS = BUS_W + 1;
    localparam int FC_W        = $clog2(TOTAL_FALLS + 1);

    typedef struct packed {
        rd_state_e         st;
        logic              cnv;
        logic              sck;
        logic              done;
        logic              tmo;
        logic [FC_W-1:0]   falls;
        logic [BUS_W-1:0]  data;
    } regs_t;

    regs_t r_d, r_q;

    logic             half_tick;
    logic             wait_tick;
    logic             shift_en;
    logic [BUS_W-1:0] cap_q;

    rd_cycle_timer #(.LIMIT(HALF_DIV)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (r_q.st == ST_SHIFT),
        .tick  (half_tick)
    );

    rd_cycle_timer #(.LIMIT(WAIT_LIMIT)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (r_q.st == ST_WAIT),
        .tick  (wait_tick)
    );

    // Capture on the edge that drives SCK low; the first fall carries busy.
    assign shift_en = (r_q.st == ST_SHIFT) && half_tick && r_q.sck
                      && (r_q.falls != '0);

    rd_capture_shreg #(.W(BUS_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_i    (sdi_i),
        .q        (cap_q)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.tmo  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.sck = 1'b1;
                r_d.cnv = 1'b0;
                if (start_i) begin
                    r_d.st    = ST_WAIT;
                    r_d.cnv   = 1'b1;
                    r_d.falls = '0;
                end
            end
            ST_WAIT: begin
                if (sdi_i) begin
                    r_d.st = ST_SHIFT;
                end else if (wait_tick) begin
                    r_d.st  = ST_IDLE;
                    r_d.cnv = 1'b0;
                    r_d.tmo = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (half_tick) begin
                    if (r_q.sck) begin
                        r_d.sck   = 1'b0;
                        r_d.falls = r_q.falls + FC_W'(1);
                    end else begin
                        r_d.sck = 1'b1;
                        if (r_q.falls == FC_W'(TOTAL_FALLS)) begin
                            r_d.st   = ST_IDLE;
                            r_d.cnv  = 1'b0;
                            r_d.done = 1'b1;
                            r_d.data = cap_q;
                        end
                    end
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.cnv = 1'b0;
                r_d.sck = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.sck   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnv_o     = r_q.cnv;
    assign sck_o     = r_q.sck;
    assign done_o    = r_q.done;
    assign timeout_o = r_q.tmo;
    assign data_o    = r_q.data;
endmodule

// File: rtl/chain_adc_reader_chk.sv
module chain_adc_reader_chk #(
    parameter int NDEV   = 3,
    parameter int WORD_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sdi_i,
    input logic                   cnv_o,
    input logic                   sck_o,
    input logic [NDEV*WORD_W-1:0] data_o,
    input logic                   done_o,
    input logic                   timeout_o
);
    localparam int TOTAL = NDEV * WORD_W + 1;

    logic        cnv_prev, sck_prev, seen_busy;
    logic [15:0] fall_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_prev  <= 1'b0;
            sck_prev  <= 1'b1;
            seen_busy <= 1'b0;
            fall_cnt  <= '0;
        end else begin
            cnv_prev <= cnv_o;
            sck_prev <= sck_o;
            if (!cnv_o)            seen_busy <= 1'b0;
            else if (sdi_i)        seen_busy <= 1'b1;
            if (cnv_o && !cnv_prev)     fall_cnt <= '0;
            else if (sck_prev && !sck_o) fall_cnt <= fall_cnt + 16'd1;
        end
    end

    a_r1_idle_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_o |-> sck_o);

    a_r2_sck_high_at_cnv_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> sck_o);

    a_r3_no_clock_before_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_o && !seen_busy) |-> sck_o);

    a_r4_fall_count: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fall_cnt == 16'(TOTAL)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_cnv_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_o) |-> (done_o || timeout_o));

    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(data_o));

    a_r8_timeout_clean: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!done_o && !cnv_o));
endmodule

bind chain_adc_reader chain_adc_reader_chk #(
    .NDEV   (NDEV),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdi_i     (sdi_i),
    .cnv_o     (cnv_o),
    .sck_o     (sck_o),
    .data_o    (data_o),
    .done_o    (done_o),
    .timeout_o (timeout_o)
);

// File: tb/sim_chain_adc_reader.sv
`timescale 1ns/1ps
module sim_chain_adc_reader;
    localparam int NDEV       = 3;
    localparam int WORD_W     = 16;
    localparam int HALF_DIV   = 2;
    localparam int WAIT_LIMIT = 64;
    localparam int BUS_W      = NDEV * WORD_W;
    localparam int PERIOD_NS  = 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdi = 1'b0;
    logic cnv, sck, done, tmo;
    logic [BUS_W-1:0] data;

    always #2 clk = ~clk;

    chain_adc_reader #(
        .NDEV(NDEV), .WORD_W(WORD_W), .HALF_DIV(HALF_DIV), .WAIT_LIMIT(WAIT_LIMIT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sdi_i(sdi),
        .cnv_o(cnv), .sck_o(sck), .data_o(data), .done_o(done), .timeout_o(tmo)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Converter chain model: line changes 1 ns after each SCK fall.
    logic [BUS_W-1:0] stream;
    int  idx = 0, falls_seen = 0, done_cnt = 0;
    bit  model_on = 0, sck_at_rise = 0;
    time t_fall2 = 0, per_meas = 0;

    always @(negedge sck) begin
        if (cnv) begin
            falls_seen++;
            if (falls_seen == 2) t_fall2 = $time;
            if (falls_seen == 3) per_meas = $time - t_fall2;
        end
        if (model_on) begin
            #1;
            if (idx < BUS_W) sdi = stream[BUS_W-1-idx];
            else             sdi = 1'b0;
            idx++;
        end
    end

    always @(posedge cnv) sck_at_rise = sck;
    always @(negedge clk) if (done) done_cnt++;

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_xfer(input logic [BUS_W-1:0] s, input int conv_dly, input bit poke);
        int w;
        int dc0;
        stream = s; idx = 0; falls_seen = 0; model_on = 0; sdi = 1'b0;
        dc0 = done_cnt;
        pulse_start();
        chk("R2 cnv raised on start edge", BUS_W'(cnv), 1);
        chk("R2 sck high at cnv rise", BUS_W'(sck_at_rise), 1);
        for (int i = 0; i < conv_dly; i++) begin
            @(negedge clk);
            if (poke && i == 0) start = 1'b1;
            chk("R3 sck idle while busy low", BUS_W'(sck & cnv), 1);
            start = 1'b0;
        end
        model_on = 1; sdi = 1'b1;
        w = 0;
        while (!done && w < 2000) begin
            @(negedge clk);
            w++;
            if (poke && w == 30) start = 1'b1;
            if (poke && w == 31) start = 1'b0;
        end
        chk("R7 done observed", BUS_W'(done), 1);
        chk("R5 R6 word placement", data, s);
        chk("R4 fall count", BUS_W'(falls_seen), BUS_W'(BUS_W + 1));
        chk("R4 sck period", BUS_W'(per_meas), BUS_W'(2 * HALF_DIV * PERIOD_NS));
        chk("R7 cnv low at done", BUS_W'(cnv), 0);
        chk("R7 sck high at done", BUS_W'(sck), 1);
        model_on = 0; sdi = 1'b0;
        @(negedge clk);
        chk("R7 done single cycle", BUS_W'(done), 0);
        chk("R7 data held", data, s);
        if (poke) begin
            bit cnv_seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (cnv) cnv_seen = 1;
            end
            chk("R9 no extra transaction", BUS_W'(cnv_seen), 0);
            chk("R9 one done only", BUS_W'(done_cnt - dc0), 1);
        end
    endtask

    task automatic run_timeout(input logic [BUS_W-1:0] prev);
        int cyc = 0;
        int dc0;
        bit sck_low = 0;
        dc0 = done_cnt;
        sdi = 1'b0; model_on = 0;
        pulse_start();
        while (!tmo && cyc < 500) begin
            @(negedge clk);
            cyc++;
            if (!sck) sck_low = 1;
        end
        chk("R8 timeout latency", BUS_W'(cyc), BUS_W'(WAIT_LIMIT));
        chk("R8 cnv low on timeout", BUS_W'(cnv), 0);
        chk("R8 no sck pulse", BUS_W'(sck_low), 0);
        chk("R8 data untouched", data, prev);
        @(negedge clk);
        chk("R8 timeout single cycle", BUS_W'(tmo), 0);
        chk("R8 no done", BUS_W'(done_cnt - dc0), 0);
    endtask

    function automatic logic [BUS_W-1:0] make_pat(input int p);
        logic [BUS_W-1:0] s;
        for (int k = 0; k < NDEV; k++) begin
            logic [15:0] wv;
            if (p == 0)      wv = 16'h0000;
            else if (p == 1) wv = 16'hFFFF;
            else if (p == 2) wv = 16'h8001 >> k;
            else             wv = (16'(p) * 16'h1357 + 16'(k) * 16'h0F0F) ^ (16'h8000 >> (p % 16));
            s[BUS_W-1-16*k -: 16] = wv;
        end
        return s;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset cnv", BUS_W'(cnv), 0);
        chk("R1 reset sck", BUS_W'(sck), 1);
        chk("R1 reset done", BUS_W'(done), 0);
        chk("R1 reset timeout", BUS_W'(tmo), 0);
        chk("R1 reset data", data, '0);
        run_timeout('0);
        for (int p = 0; p < 20; p++) begin
            run_xfer(make_pat(p), 1 + (p % 5), (p % 4) == 3);
            if (p == 10) run_timeout(make_pat(p));
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(PERIOD_NS * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule